// File: doc/BRIEF.md
# Three-wire serial EEPROM word master

This block drives a three-wire serial EEPROM that holds 64 words of 16 bits. It owns the chip-select, serial-clock and serial-data-in pins, samples the serial-data-out pin, and offers the host a one-word request interface. Each request is either a word read or a word write. The block answers with a one-cycle acknowledge that carries the read word, or for a write an error flag that reports a device that never signalled completion.

All pin activity is paced by a delay unit. The unit is set at run time by a prescaler value, so one controller serves slow and fast parts. Internally a short per-operation program of micro-operations is stepped: bus setup, field shifts out and in, the standby chip-select toggle, completion polling, and the closing clock pulse. A pin-level engine carries out each micro-operation one delay unit at a time.

Top module: `mwm_master`

## Requirements
- R1: While reset is applied and after it is released, ee_cs, ee_sk, ee_di and ack are low. Whenever no request is being served, ee_sk stays low.
- R2: A request is req high for one cycle. It is taken only while the block is idle. A req raised while an operation runs is dropped: it produces no ack and no change to the device.
- R3: One delay unit lasts unit_div+1 clock cycles, with unit_div at least 2. Pins change only at unit boundaries. Every serial-clock high phase of a data bit lasts exactly one unit.
- R4: Every field is shifted most significant bit first. ee_di takes its bit one unit before the rising clock edge and changes only while ee_sk is low.
- R5: A read lowers ee_sk and ee_di before chip select is raised. It then sends 3'b110 and the 6-bit address, and clocks in 16 bits MSB first. ee_do is sampled at the end of each clock-high unit while ee_di is held at 0. The ack then carries the word in rdata, with err low.
- R6: A read ends with the standby sequence: cs and sk low, then sk high, then cs high, then sk low. Each step lasts one unit. The bus is left with ee_cs high and ee_sk low.
- R7: A write sends 5'b10011 followed by ADDR_W-2 zero bits, then a standby, then 3'b101, the address and the 16 data bits, in that order.
- R8: After the data bits, a standby follows. ee_do is then sampled once per unit, and the first high sample ends polling with err low.
- R9: If ee_do is still low after POLL_MAX (200) samples, polling stops and the write is acknowledged with err high.
- R10: After polling, whatever its outcome, the block performs a standby and then sends 5'b10000 followed by ADDR_W-2 zero bits.
- R11: A write closes by driving ee_cs and ee_di low, then one full clock pulse. At the ack of a write, ee_cs, ee_sk and ee_di are all low.
- R12: ee_di returns to 0 after every shifted-out field. All padding bits are zero.
- R13: ack is high for exactly one cycle. rdata is valid with it and reads as 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_div | input | DIV_W | Delay unit length minus one, in clock cycles |
| req | input | 1 | Request pulse, taken when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Word to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Word read, valid with ack |
| err | output | 1 | Write completion timed out, valid with ack |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
A behavioural device model decodes every frame bit by bit and counts malformed frames. Reads of all-ones, all-zeros and mixed words, and reads at both address extremes, confirm bit order and address alignment. Writes are tried against a device that finishes quickly and one that never finishes. Comparing their latency and error flag separates early poll exit from timeout, and the disable frame that follows each of them is checked. Two prescaler settings are compared through the measured clock-high width, and a request pulsed during a busy read shows that requests are taken only when idle.

// File: rtl/mwm_pkg.sv
package mwm_pkg;

  localparam int FIELD_W = 16;

  localparam logic [2:0] OPC_READ  = 3'b110;
  localparam logic [2:0] OPC_WRITE = 3'b101;
  localparam logic [4:0] OPC_WEN   = 5'b10011;
  localparam logic [4:0] OPC_WDIS  = 5'b10000;

  typedef enum logic [2:0] {
    P_SETUP, P_SEND, P_RECV, P_STBY, P_POLL, P_CLOSE
  } prim_e;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_e;

  typedef struct packed {
    prim_e               kind;
    logic [FIELD_W-1:0]  bits;
    logic [4:0]          len;
    logic                last;
  } uop_t;

  // Micro-op program of one operation, indexed by step number.
  function automatic uop_t prog_step(input logic wr, input logic [3:0] idx,
                                     input logic [FIELD_W-1:0] a,
                                     input logic [FIELD_W-1:0] d,
                                     input logic [4:0] alen,
                                     input logic [4:0] dlen);
    uop_t u;
    u = '{kind: P_CLOSE, bits: '0, len: 5'd0, last: 1'b1};
    if (!wr) begin
      case (idx)
        4'd0: u = '{kind: P_SETUP, bits: '0, len: 5'd0, last: 1'b0};
        4'd1: u = '{kind: P_SEND, bits: FIELD_W'(OPC_READ), len: 5'd3, last: 1'b0};
        4'd2: u = '{kind: P_SEND, bits: a, len: alen, last: 1'b0};
        4'd3: u = '{kind: P_RECV, bits: '0, len: dlen, last: 1'b0};
        default: u = '{kind: P_STBY, bits: '0, len: 5'd0, last: 1'b1};
      endcase
    end else begin
      case (idx)
        4'd0:  u = '{kind: P_SETUP, bits: '0, len: 5'd0, last: 1'b0};
        4'd1:  u = '{kind: P_SEND, bits: FIELD_W'(OPC_WEN), len: 5'd5, last: 1'b0};
        4'd2:  u = '{kind: P_SEND, bits: '0, len: alen - 5'd2, last: 1'b0};
        4'd3:  u = '{kind: P_STBY, bits: '0, len: 5'd0, last: 1'b0};
        4'd4:  u = '{kind: P_SEND, bits: FIELD_W'(OPC_WRITE), len: 5'd3, last: 1'b0};
        4'd5:  u = '{kind: P_SEND, bits: a, len: alen, last: 1'b0};
        4'd6:  u = '{kind: P_SEND, bits: d, len: dlen, last: 1'b0};
        4'd7:  u = '{kind: P_STBY, bits: '0, len: 5'd0, last: 1'b0};
        4'd8:  u = '{kind: P_POLL, bits: '0, len: 5'd0, last: 1'b0};
        4'd9:  u = '{kind: P_STBY, bits: '0, len: 5'd0, last: 1'b0};
        4'd10: u = '{kind: P_SEND, bits: FIELD_W'(OPC_WDIS), len: 5'd5, last: 1'b0};
        4'd11: u = '{kind: P_SEND, bits: '0, len: alen - 5'd2, last: 1'b0};
        default: u = '{kind: P_CLOSE, bits: '0, len: 5'd0, last: 1'b1};
      endcase
    end
    return u;
  endfunction

endpackage

// File: rtl/mwm_prescale.sv
module mwm_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == div);
    cnt_d = cnt_q;
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mwm_pinio.sv
module mwm_pinio
  import mwm_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_MAX = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  prim_e              kind,
  input  logic [FIELD_W-1:0] bits,
  input  logic [4:0]         len,
  input  logic               sdo,
  output logic               busy,
  output logic               done,
  output logic               timeout,
  output logic [DATA_W-1:0]  rdata,
  output logic               cs,
  output logic               sk,
  output logic               di
);

  localparam int PW = $clog2(POLL_MAX + 1);

  logic               busy_q, busy_d, done_q, done_d, to_q, to_d;
  prim_e              kind_q, kind_d;
  logic [1:0]         ph_q, ph_d;
  logic [4:0]         cnt_q, cnt_d;
  logic [FIELD_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]  rd_q, rd_d;
  logic [PW-1:0]      pol_q, pol_d;
  logic               cs_q, cs_d, sk_q, sk_d, di_q, di_d;
  logic [1:0]         do_s;
  logic               fin;

  always_comb begin
    busy_d = busy_q; kind_d = kind_q; ph_d = ph_q; cnt_d = cnt_q;
    sh_d = sh_q; rd_d = rd_q; pol_d = pol_q; to_d = to_q;
    cs_d = cs_q; sk_d = sk_q; di_d = di_q;
    done_d = 1'b0;
    fin = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        kind_d = kind;
        ph_d   = 2'd0;
        cnt_d  = len - 5'd1;
        sh_d   = bits << (5'd16 - len);
        pol_d  = '0;
        to_d   = 1'b0;
        case (kind)
          P_SETUP: begin sk_d = 1'b0; di_d = 1'b0; end
          P_SEND:  di_d = sh_d[FIELD_W-1];
          P_RECV:  begin sk_d = 1'b1; di_d = 1'b0; end
          P_STBY:  begin cs_d = 1'b0; sk_d = 1'b0; end
          P_CLOSE: begin cs_d = 1'b0; di_d = 1'b0; end
          default: ;
        endcase
      end
    end else if (tick) begin
      case (kind_q)
        P_SETUP: begin
          if (ph_q == 2'd0) begin cs_d = 1'b1; ph_d = 2'd1; end
          else fin = 1'b1;
        end
        P_SEND: begin
          case (ph_q)
            2'd0: begin sk_d = 1'b1; ph_d = 2'd1; end
            2'd1: begin sk_d = 1'b0; ph_d = 2'd2; end
            2'd2: begin
              if (cnt_q != 5'd0) begin
                sh_d  = sh_q << 1;
                di_d  = sh_q[FIELD_W-2];
                cnt_d = cnt_q - 5'd1;
                ph_d  = 2'd0;
              end else begin
                di_d = 1'b0;
                ph_d = 2'd3;
              end
            end
            default: fin = 1'b1;
          endcase
        end
        P_RECV: begin
          if (ph_q == 2'd0) begin
            rd_d = {rd_q[DATA_W-2:0], do_s[1]};
            sk_d = 1'b0;
            ph_d = 2'd1;
          end else if (cnt_q != 5'd0) begin
            sk_d  = 1'b1;
            cnt_d = cnt_q - 5'd1;
            ph_d  = 2'd0;
          end else begin
            fin = 1'b1;
          end
        end
        P_STBY: begin
          case (ph_q)
            2'd0: begin sk_d = 1'b1; ph_d = 2'd1; end
            2'd1: begin cs_d = 1'b1; ph_d = 2'd2; end
            2'd2: begin sk_d = 1'b0; ph_d = 2'd3; end
            default: fin = 1'b1;
          endcase
        end
        P_POLL: begin
          if (do_s[1]) fin = 1'b1;
          else if (pol_q == PW'(POLL_MAX - 1)) begin fin = 1'b1; to_d = 1'b1; end
          else pol_d = pol_q + 1'b1;
        end
        default: begin
          case (ph_q)
            2'd0: begin sk_d = 1'b1; ph_d = 2'd1; end
            2'd1: begin sk_d = 1'b0; ph_d = 2'd2; end
            default: fin = 1'b1;
          endcase
        end
      endcase
      if (fin) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; to_q <= 1'b0;
      kind_q <= P_SETUP; ph_q <= 2'd0; cnt_q <= '0;
      sh_q <= '0; rd_q <= '0; pol_q <= '0;
      cs_q <= 1'b0; sk_q <= 1'b0; di_q <= 1'b0;
      do_s <= 2'b00;
    end else begin
      busy_q <= busy_d; done_q <= done_d; to_q <= to_d;
      kind_q <= kind_d; ph_q <= ph_d; cnt_q <= cnt_d;
      sh_q <= sh_d; rd_q <= rd_d; pol_q <= pol_d;
      cs_q <= cs_d; sk_q <= sk_d; di_q <= di_d;
      do_s <= {do_s[0], sdo};
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign timeout = to_q;
  assign rdata   = rd_q;
  assign cs      = cs_q;
  assign sk      = sk_q;
  assign di      = di_q;

endmodule

// File: rtl/mwm_prog.sv
module mwm_prog
  import mwm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               eng_done,
  input  logic               eng_to,
  input  logic [DATA_W-1:0]  eng_rdata,
  output logic               start,
  output uop_t               cur,
  output logic               busy,
  output logic               ack,
  output logic [DATA_W-1:0]  rdata,
  output logic               err
);

  seq_e              st_q, st_d;
  logic [3:0]        idx_q, idx_d;
  logic              we_q, we_d, acc_q, acc_d, ack_q, ack_d, er_q, er_d;
  logic [ADDR_W-1:0] ad_q, ad_d;
  logic [DATA_W-1:0] wd_q, wd_d, rd_q, rd_d;

  assign cur = prog_step(we_q, idx_q, FIELD_W'(ad_q), FIELD_W'(wd_q),
                         5'(ADDR_W), 5'(DATA_W));

  always_comb begin
    st_d = st_q; idx_d = idx_q; we_d = we_q; ad_d = ad_q; wd_d = wd_q;
    acc_d = acc_q; rd_d = rd_q; er_d = er_q;
    ack_d = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req) begin
          we_d = we; ad_d = addr; wd_d = wdata;
          idx_d = '0; acc_d = 1'b0;
          st_d = S_ISSUE;
        end
      end
      S_ISSUE: st_d = S_WAIT;
      S_WAIT: begin
        if (eng_done) begin
          acc_d = acc_q | eng_to;
          if (cur.last) begin
            ack_d = 1'b1;
            rd_d  = we_q ? '0 : eng_rdata;
            er_d  = acc_q | eng_to;
            st_d  = S_IDLE;
          end else begin
            idx_d = idx_q + 4'd1;
            st_d  = S_ISSUE;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; idx_q <= '0; we_q <= 1'b0; ad_q <= '0; wd_q <= '0;
      acc_q <= 1'b0; ack_q <= 1'b0; rd_q <= '0; er_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; we_q <= we_d; ad_q <= ad_d; wd_q <= wd_d;
      acc_q <= acc_d; ack_q <= ack_d; rd_q <= rd_d; er_q <= er_d;
    end
  end

  assign start = (st_q == S_ISSUE);
  assign busy  = (st_q != S_IDLE);
  assign ack   = ack_q;
  assign rdata = rd_q;
  assign err   = er_q;

endmodule

// File: rtl/mwm_master.sv
module mwm_master
  import mwm_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 8,
  parameter int POLL_MAX = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  unit_div,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  logic              tick_w, start_w, eng_busy, eng_done, eng_to, seq_busy;
  logic [DATA_W-1:0] eng_rdata;
  uop_t              cur_w;

  mwm_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(eng_busy), .div(unit_div), .tick(tick_w)
  );

  mwm_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .eng_done(eng_done), .eng_to(eng_to), .eng_rdata(eng_rdata),
    .start(start_w), .cur(cur_w), .busy(seq_busy),
    .ack(ack), .rdata(rdata), .err(err)
  );

  mwm_pinio #(.DATA_W(DATA_W), .POLL_MAX(POLL_MAX)) u_pin (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .start(start_w),
    .kind(cur_w.kind), .bits(cur_w.bits), .len(cur_w.len), .sdo(ee_do),
    .busy(eng_busy), .done(eng_done), .timeout(eng_to), .rdata(eng_rdata),
    .cs(ee_cs), .sk(ee_sk), .di(ee_di)
  );

endmodule

// File: rtl/mwm_master_chk.sv
module mwm_master_chk (
  input logic clk,
  input logic rst_n,
  input logic ack,
  input logic err,
  input logic cs,
  input logic sk,
  input logic di,
  input logic tick,
  input logic start,
  input logic seq_busy
);

  // R13: acknowledge is a single-cycle pulse
  a_r13_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R4: data-in moves only while the serial clock is low
  a_r4_di_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(di) |-> (!sk && !$past(sk)));

  // R3: pins move only at a delay-unit boundary or a step start
  a_r3_pins_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cs, sk, di}) |-> ($past(tick) || $past(start)));

  // R1: serial clock stays low with no operation in flight
  a_r1_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !sk);

  // R11: a timed-out write is still closed with cs, sk, di low
  a_r11_write_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && err) |-> (!cs && !sk && !di));

  // R2: an acknowledge only ends a request in flight
  a_r2_ack_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(seq_busy));

endmodule

bind mwm_master mwm_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .err(err),
  .cs(ee_cs), .sk(ee_sk), .di(ee_di),
  .tick(tick_w), .start(start_w), .seq_busy(seq_busy)
);

// File: tb/mwm_master_tb_top.sv
`timescale 1ns/1ps
module mwm_master_tb_top;

  localparam int POLL_MAX = 200;
  localparam int BUSY     = 40;
  localparam int WD_LIMIT = 150000;

  logic        clk, rst_n, req, we, ack, err, ee_cs, ee_sk, ee_di, ee_do;
  logic [7:0]  unit_div;
  logic [5:0]  addr;
  logic [15:0] wdata, rdata;

  mwm_master dut_i (
    .clk(clk), .rst_n(rst_n), .unit_div(unit_div), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata), .err(err),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, n_ack = 0;
  int req_cyc = 0, last_lat = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [15:0] mem [64];
  logic [15:0] shadow [64];
  logic [31:0] cmd;
  int  nb, rd_i, busy_cnt, hi_cnt, min_hi;
  int  m_read, m_write, m_ewen, m_ewds, m_bad;
  bit  m_wen, rd_on, pend, stat, stuck, prv_cs, prv_sk;
  logic [5:0] rd_a;
  logic do_r;
  assign ee_do = do_r;

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]    = 16'(i * 16'h0935) ^ 16'h5A3C;
      shadow[i] = 16'(i * 16'h0935) ^ 16'h5A3C;
    end
    cmd = 0; nb = 0; rd_i = 0; busy_cnt = 0; hi_cnt = 0; min_hi = 999;
    m_read = 0; m_write = 0; m_ewen = 0; m_ewds = 0; m_bad = 0;
    m_wen = 0; rd_on = 0; pend = 0; stat = 0; stuck = 0;
    prv_cs = 0; prv_sk = 0; do_r = 1'b0; rd_a = '0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_sk) hi_cnt++;
      else if (prv_sk) begin
        if (hi_cnt < min_hi) min_hi = hi_cnt;
        hi_cnt = 0;
      end
      if (busy_cnt > 0) busy_cnt--;
      if (prv_cs && !ee_cs) begin
        if (rd_on) begin
          if (nb != 25) m_bad++;
        end else if (nb == 9 && cmd[8:0] == 9'b100110000) begin
          m_wen = 1; m_ewen++;
        end else if (nb == 9 && cmd[8:0] == 9'b100000000) begin
          m_wen = 0; m_ewds++;
        end else if (nb == 25 && cmd[24:22] == 3'b101) begin
          if (m_wen) begin
            mem[cmd[21:16]] = cmd[15:0]; m_write++; pend = 1; busy_cnt = BUSY;
          end else m_bad++;
        end else if (nb != 0) m_bad++;
        nb = 0; rd_on = 0; rd_i = 0; stat = 0; do_r = 1'b0; cmd = 0;
      end
      if (!prv_cs && ee_cs && pend) begin stat = 1; pend = 0; end
      if (ee_cs && ee_sk && !prv_sk) begin
        nb++;
        if (rd_on) begin
          if (ee_di) m_bad++;
          if (rd_i > 0) begin do_r = mem[rd_a][rd_i-1]; rd_i--; end
          else m_bad++;
        end else begin
          cmd = {cmd[30:0], ee_di};
          if (nb == 9 && cmd[8:6] == 3'b110) begin
            rd_on = 1; rd_a = cmd[5:0]; rd_i = 16; m_read++;
          end
        end
      end
      if (stat) do_r = (busy_cnt == 0) && !stuck;
      prv_cs = ee_cs; prv_sk = ee_sk;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit w; logic [15:0] d; bit e; } exp_t;
  exp_t exp_q[$];
  bit   ack_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_prev) chk(!ack, "R13 ack width", ack, 0);
      if (ack) begin
        last_lat = cyc - req_cyc;
        if (exp_q.size() == 0) chk(0, "R2 unexpected ack", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rdata == e.d, e.w ? "R13 write rdata" : "R5 read data", rdata, e.d);
          chk(err == e.e, e.w ? "R9 write err" : "R5 read err", err, e.e);
        end
        n_ack++;
      end
      ack_prev = ack;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL R13 watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- driver ----------------
  task automatic issue(bit w, logic [5:0] a, logic [15:0] d, bit e, bit push);
    exp_t x;
    if (push) begin
      x.w = w; x.d = w ? 16'h0 : shadow[a]; x.e = e;
      exp_q.push_back(x);
      if (w) shadow[a] = d;
      @(posedge clk); min_hi = 999;
    end
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    if (push) req_cyc = cyc;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_ack(int k);
    do @(posedge clk); while (n_ack == k);
    #2;
  endtask

  task automatic op(bit w, logic [5:0] a, logic [15:0] d, bit e);
    int k;
    k = n_ack;
    issue(w, a, d, e, 1'b1);
    wait_ack(k);
  endtask

  int r0, w0, e0, d0, b0, lat_ok;

  task automatic snap();
    r0 = m_read; w0 = m_write; e0 = m_ewen; d0 = m_ewds; b0 = m_bad;
  endtask

  task automatic after_read(string tag);
    chk(m_read == r0 + 1, "R5 one read frame", m_read - r0, 1);
    chk(m_bad == b0, "R4 frame well formed", m_bad - b0, 0);
    chk(ee_cs == 1'b1 && ee_sk == 1'b0, "R6 standby leaves cs high sk low",
        {ee_cs, ee_sk}, 2'b10);
    chk(ee_di == 1'b0, "R12 di low after read", ee_di, 0);
    chk(min_hi == int'(unit_div) + 1, {"R3 clock high width ", tag}, min_hi,
        int'(unit_div) + 1);
  endtask

  task automatic after_write();
    chk(m_ewen == e0 + 1, "R7 enable frame", m_ewen - e0, 1);
    chk(m_write == w0 + 1, "R7 write frame", m_write - w0, 1);
    chk(m_ewds == d0 + 1 && !m_wen, "R10 disable frame", m_ewds - d0, 1);
    chk(m_bad == b0, "R12 zero padding and framing", m_bad - b0, 0);
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R11 closed bus", {ee_cs, ee_sk, ee_di}, 0);
    chk(min_hi == int'(unit_div) + 1, "R3 clock high width write", min_hi,
        int'(unit_div) + 1);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; unit_div = 8'd2;
    repeat (4) @(posedge clk);
    #2;
    chk({ee_cs, ee_sk, ee_di, ack} == 4'b0, "R1 pins in reset", {ee_cs, ee_sk, ee_di, ack}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    chk({ee_cs, ee_sk, ee_di, ack} == 4'b0, "R1 pins after reset", {ee_cs, ee_sk, ee_di, ack}, 0);

    snap(); op(0, 6'd0, 16'h0, 0);  after_read("div2");
    snap(); op(0, 6'd63, 16'h0, 0); after_read("addr63");

    snap(); op(1, 6'd21, 16'hFFFF, 0); after_write();
    lat_ok = last_lat;
    chk(lat_ok < POLL_MAX * 3, "R8 early poll exit", lat_ok, POLL_MAX * 3);
    snap(); op(0, 6'd21, 16'h0, 0); after_read("ones");
    snap(); op(1, 6'd42, 16'h0000, 0); after_write();
    snap(); op(0, 6'd42, 16'h0, 0); after_read("zeros");

    unit_div = 8'd4;
    snap(); op(0, 6'd5, 16'h0, 0); after_read("div4");
    snap(); op(1, 6'd7, 16'h8001, 0); after_write();
    snap(); op(0, 6'd7, 16'h0, 0); after_read("edges");

    unit_div = 8'd2;
    stuck = 1;
    snap(); op(1, 6'd10, 16'h1234, 1); after_write();
    chk(last_lat >= POLL_MAX * 3, "R9 full poll window", last_lat, POLL_MAX * 3);
    stuck = 0;
    snap(); op(0, 6'd10, 16'h0, 0); after_read("after timeout");

    // R2: request during a busy read is dropped
    begin
      int k;
      k = n_ack;
      snap();
      issue(0, 6'd3, 16'h0, 0, 1'b1);
      repeat (20) @(posedge clk);
      issue(1, 6'd3, 16'hBEEF, 0, 1'b0);
      wait_ack(k);
      repeat (1200) @(posedge clk);
      #2;
      chk(n_ack == k + 1, "R2 single ack", n_ack - k, 1);
      chk(m_write == w0 && m_ewen == e0, "R2 no write issued", m_write - w0, 0);
    end
    snap(); op(0, 6'd3, 16'h0, 0); after_read("R2 readback");

    chk(exp_q.size() == 0, "R13 all acks seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule